// File: doc/BRIEF.md
# Six-Channel PPM Frame Generator

This block turns a set of channel widths, each given as a count of clock cycles, into a serial pulse-position-modulated line for a radio-control receiver or servo chain. Every frame opens with a low separator of fixed length, then gives each channel in turn a high pulse as long as its width value. Each channel pulse is followed by another low separator. After the last channel's pulse and its closing separator, the line rests high until the frame has used up its fixed period. The next frame then begins straight away.

The widths are copied into a private register set on the clock edge at which a frame begins. The surrounding logic can therefore rewrite its values at any time without tearing a frame that is already on the line. A one-cycle done strobe marks the final cycle of each frame. When the channel pulses are so long that the frame period would be overrun, the resting high is cut back, but never to less than one separator length. Separator length, frame period, channel count and value width are parameters. At the defaults with a 125 MHz clock they give 400 us separators and a 20 ms frame.

Top module: `ppm_frame_gen`

## Requirements
- R1: While rst_n is low, ppm_o is high and frame_done_o is low. In the first cycle after release the line stays high. The first separator begins at the next rising clock edge.
- R2: Every separator holds ppm_o low for exactly SEP_CYCLES cycles. A frame has NUM_CH+1 separators: one before each channel pulse and one after the last.
- R3: Channel k (k = 0 first, taken from chan_vals_i[k*VAL_W +: VAL_W]) drives ppm_o high for exactly its value in cycles. Channels go out in ascending index order.
- R4: Let U be the number of cycles from the first separator up to the end of the trailing separator. When U + SEP_CYCLES <= FRAME_CYCLES, the idle high lasts FRAME_CYCLES - U cycles, so the frame is exactly FRAME_CYCLES long.
- R5: When U + SEP_CYCLES > FRAME_CYCLES, the idle high lasts exactly SEP_CYCLES cycles.
- R6: frame_done_o is high for one cycle only, in the last idle cycle of each frame, while ppm_o is high. In the next cycle ppm_o is low.
- R7: Channel values are sampled on the clock edge at which a frame's first separator begins. A change applied later takes effect only in the following frame.
- R8: A channel value of 0 gives no high pulse. The separators on either side of it join into one low run of 2*SEP_CYCLES cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_vals_i | input | NUM_CH*VAL_W | Packed channel widths in cycles, channel 0 in the lowest bits |
| ppm_o | output | 1 | Serial PPM line, high at rest |
| frame_done_o | output | 1 | One-cycle strobe in the last cycle of each frame |

## Verification
A wrong state or channel index inside the generator appears on ppm_o within the same segment. It shows as a separator of the wrong length, a channel pulse taken from the wrong slot, or a missing trailing separator. The reference model therefore flags it in that cycle, and it does not drift into later frames unseen. A faulty frame counter or idle computation changes where the done strobe falls, so it shows in the first frame it affects. Overrun frames and zero-width channels are driven on purpose so that the clamp and the separator-merge paths are also seen at the line.

// File: rtl/ppm_gen_pkg.sv
package ppm_gen_pkg;

   // Segment the line is currently producing
   typedef enum logic [2:0] {
      ST_BOOT = 3'd0,
      ST_SEP  = 3'd1,
      ST_CHAN = 3'd2,
      ST_TAIL = 3'd3,
      ST_IDLE = 3'd4
   } seg_e;

endpackage

// File: rtl/ppm_gen_shadow.sv
// Per-frame copy of the channel widths and the selector onto the active slot
module ppm_gen_shadow #(
   parameter int NUM_CH = 6,
   parameter int VAL_W  = 32,
   parameter int CH_W   = 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    load_i,
   input  logic [NUM_CH*VAL_W-1:0] val_flat_i,
   input  logic [CH_W-1:0]         sel_i,
   output logic [VAL_W-1:0]        sel_val_o
);

   logic [VAL_W-1:0] held [NUM_CH];

   generate
      for (genvar g = 0; g < NUM_CH; g++) begin : g_slot
         logic [VAL_W-1:0] slot_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      slot_q <= '0;
            else if (load_i) slot_q <= val_flat_i[g*VAL_W +: VAL_W];
         end
         assign held[g] = slot_q;
      end

      if (NUM_CH == 1) begin : g_single
         assign sel_val_o = held[0];
      end else begin : g_multi
         always_comb begin
            sel_val_o = '0;
            for (int i = 0; i < NUM_CH; i++) begin
               if (int'(sel_i) == i) sel_val_o = held[i];
            end
         end
      end
   endgenerate

endmodule

// File: rtl/ppm_gen_timer.sv
// Segment length counter and whole-frame elapsed counter
module ppm_gen_timer #(
   parameter int LEN_W = 32,
   parameter int CNT_W = 36
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             seg_start_i,
   input  logic [LEN_W-1:0] seg_len_i,
   input  logic             frame_start_i,
   output logic             seg_last_o,
   output logic [CNT_W-1:0] elapsed_o
);

   logic [LEN_W-1:0] seg_len_q;
   logic [LEN_W-1:0] seg_cnt_q;
   logic [CNT_W-1:0] frame_cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seg_len_q <= LEN_W'(1);
         seg_cnt_q <= '0;
      end else if (seg_start_i) begin
         seg_len_q <= seg_len_i;
         seg_cnt_q <= '0;
      end else begin
         seg_cnt_q <= seg_cnt_q + LEN_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 frame_cnt_q <= '0;
      else if (frame_start_i)     frame_cnt_q <= '0;
      else if (frame_cnt_q != '1) frame_cnt_q <= frame_cnt_q + CNT_W'(1);
   end

   assign seg_last_o = (seg_cnt_q == (seg_len_q - LEN_W'(1)));
   assign elapsed_o  = frame_cnt_q;

endmodule

// File: rtl/ppm_gen_fsm.sv
// State register, next-segment decision and line decode
module ppm_gen_fsm
   import ppm_gen_pkg::*;
#(
   parameter int NUM_CH       = 6,
   parameter int VAL_W        = 32,
   parameter int CH_W         = 3,
   parameter int LEN_W        = 32,
   parameter int CNT_W        = 36,
   parameter int SEP_CYCLES   = 50000,
   parameter int FRAME_CYCLES = 2500000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             seg_last_i,
   input  logic [CNT_W-1:0] elapsed_i,
   input  logic [VAL_W-1:0] chan_val_i,
   output logic [CH_W-1:0]  ch_sel_o,
   output logic             seg_start_o,
   output logic [LEN_W-1:0] seg_len_o,
   output logic             frame_start_o,
   output logic             ppm_o,
   output logic             done_o
);

   localparam logic [LEN_W-1:0] SEP_LEN  = LEN_W'(SEP_CYCLES);
   localparam logic [CNT_W-1:0] SEP_CNT  = CNT_W'(SEP_CYCLES);
   localparam logic [CNT_W-1:0] FRM_CNT  = CNT_W'(FRAME_CYCLES);
   localparam logic [CH_W-1:0]  LAST_CH  = CH_W'(NUM_CH - 1);

   seg_e             state_q, state_d;
   logic [CH_W-1:0]  ch_q, ch_d;
   logic [CNT_W-1:0] used;
   logic [LEN_W-1:0] idle_len;

   // Idle fill: remainder of the frame, floored at one separator
   always_comb begin
      used = elapsed_i + CNT_W'(1);
      if ((used + SEP_CNT) <= FRM_CNT) idle_len = LEN_W'(FRM_CNT - used);
      else                             idle_len = SEP_LEN;
   end

   always_comb begin
      state_d       = state_q;
      ch_d          = ch_q;
      seg_len_o     = SEP_LEN;
      frame_start_o = 1'b0;
      if (seg_last_i) begin
         unique case (state_q)
            ST_BOOT, ST_IDLE: begin
               state_d       = ST_SEP;
               ch_d          = '0;
               frame_start_o = 1'b1;
            end
            ST_SEP: begin
               if (chan_val_i != '0) begin
                  state_d   = ST_CHAN;
                  seg_len_o = LEN_W'(chan_val_i);
               end else if (ch_q == LAST_CH) begin
                  state_d = ST_TAIL;
               end else begin
                  ch_d = CH_W'(ch_q + 1'b1);
               end
            end
            ST_CHAN: begin
               state_d = (ch_q == LAST_CH) ? ST_TAIL : ST_SEP;
               if (ch_q != LAST_CH) ch_d = CH_W'(ch_q + 1'b1);
            end
            ST_TAIL: begin
               state_d   = ST_IDLE;
               seg_len_o = idle_len;
            end
            default: state_d = ST_BOOT;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_BOOT;
         ch_q    <= '0;
      end else begin
         state_q <= state_d;
         ch_q    <= ch_d;
      end
   end

   assign ch_sel_o    = ch_q;
   assign seg_start_o = seg_last_i;
   assign ppm_o       = (state_q == ST_BOOT) || (state_q == ST_CHAN) || (state_q == ST_IDLE);
   assign done_o      = (state_q == ST_IDLE) && seg_last_i;

endmodule

// File: rtl/ppm_frame_gen.sv
module ppm_frame_gen #(
   parameter int NUM_CH       = 6,
   parameter int VAL_W        = 32,
   parameter int SEP_CYCLES   = 50000,
   parameter int FRAME_CYCLES = 2500000
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NUM_CH*VAL_W-1:0] chan_vals_i,
   output logic                    ppm_o,
   output logic                    frame_done_o
);

   localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
   localparam int FRM_W = $clog2(FRAME_CYCLES + 1);
   localparam int LEN_W = (VAL_W > FRM_W) ? VAL_W : FRM_W;
   localparam int CNT_W = LEN_W + $clog2(NUM_CH + 2) + 1;

   generate
      if (NUM_CH < 1)       begin : g_bad_ch   $error("NUM_CH must be at least 1"); end
      if (VAL_W < 1)        begin : g_bad_val  $error("VAL_W must be at least 1"); end
      if (SEP_CYCLES < 1)   begin : g_bad_sep  $error("SEP_CYCLES must be at least 1"); end
      if (FRAME_CYCLES < 2*SEP_CYCLES) begin : g_bad_frm
         $error("FRAME_CYCLES must cover at least two separators");
      end
   endgenerate

   logic             seg_last;
   logic             seg_start;
   logic             frame_start;
   logic [LEN_W-1:0] seg_len;
   logic [CNT_W-1:0] elapsed;
   logic [CH_W-1:0]  ch_sel;
   logic [VAL_W-1:0] ch_val;

   ppm_gen_shadow #(.NUM_CH(NUM_CH), .VAL_W(VAL_W), .CH_W(CH_W)) u_shadow (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (frame_start),
      .val_flat_i (chan_vals_i),
      .sel_i      (ch_sel),
      .sel_val_o  (ch_val)
   );

   ppm_gen_timer #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_timer (
      .clk           (clk),
      .rst_n         (rst_n),
      .seg_start_i   (seg_start),
      .seg_len_i     (seg_len),
      .frame_start_i (frame_start),
      .seg_last_o    (seg_last),
      .elapsed_o     (elapsed)
   );

   ppm_gen_fsm #(
      .NUM_CH(NUM_CH), .VAL_W(VAL_W), .CH_W(CH_W), .LEN_W(LEN_W), .CNT_W(CNT_W),
      .SEP_CYCLES(SEP_CYCLES), .FRAME_CYCLES(FRAME_CYCLES)
   ) u_fsm (
      .clk           (clk),
      .rst_n         (rst_n),
      .seg_last_i    (seg_last),
      .elapsed_i     (elapsed),
      .chan_val_i    (ch_val),
      .ch_sel_o      (ch_sel),
      .seg_start_o   (seg_start),
      .seg_len_o     (seg_len),
      .frame_start_o (frame_start),
      .ppm_o         (ppm_o),
      .done_o        (frame_done_o)
   );

endmodule

// File: rtl/ppm_frame_gen_chk.sv
module ppm_frame_gen_chk #(
   parameter int SEP_CYCLES = 50000
) (
   input logic clk,
   input logic rst_n,
   input logic ppm_o,
   input logic frame_done_o
);

   localparam logic [47:0] SEP_L = 48'(SEP_CYCLES);

   logic [47:0] low_run_q;
   logic [47:0] high_run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_run_q  <= '0;
         high_run_q <= '0;
      end else begin
         low_run_q  <= ppm_o ? '0 : low_run_q + 48'd1;
         high_run_q <= ppm_o ? high_run_q + 48'd1 : '0;
      end
   end

   // R1: line at rest level while reset is held
   always @(negedge clk) begin
      if (!rst_n) begin
         a_r1_reset_level: assert (ppm_o && !frame_done_o);
      end
   end

   // R2 and R8: every low run is a whole number of separators
   a_r2_sep_multiple: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ppm_o) |-> ((low_run_q != '0) && ((low_run_q % SEP_L) == '0)));

   // R5: the idle run is never shorter than one separator
   a_r5_idle_floor: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done_o |-> ((high_run_q + 48'd1) >= SEP_L));

   // R6: done strobe lands on a high cycle
   a_r6_done_high: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done_o |-> ppm_o);

   // R6: next frame's separator follows the strobe
   a_r6_done_then_low: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done_o |=> (!ppm_o && !frame_done_o));

endmodule

bind ppm_frame_gen ppm_frame_gen_chk #(.SEP_CYCLES(SEP_CYCLES)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .ppm_o        (ppm_o),
   .frame_done_o (frame_done_o)
);

// File: tb/ppm_frame_gen_test.sv
module ppm_frame_gen_test;

   localparam int NCH = 6;
   localparam int VW  = 32;
   localparam int SEP = 8;
   localparam int FRM = 200;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [NCH*VW-1:0] vals = '0;
   logic              ppm;
   logic              done;

   int checks = 0;
   int failures = 0;
   int cyc = 0;

   bit    exp_lvl [$];
   bit    exp_dn  [$];
   string exp_tag [$];
   string chan_tag = "R3";

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   ppm_frame_gen #(.NUM_CH(NCH), .VAL_W(VW), .SEP_CYCLES(SEP), .FRAME_CYCLES(FRM)) uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .chan_vals_i  (vals),
      .ppm_o        (ppm),
      .frame_done_o (done)
   );

   task automatic set_vals(input int a, input int b, input int c,
                           input int d, input int e, input int f);
      int v [NCH];
      v = '{a, b, c, d, e, f};
      for (int i = 0; i < NCH; i++) vals[i*VW +: VW] = VW'(v[i]);
   endtask

   task automatic push(input int n, input bit lvl, input string tag);
      for (int i = 0; i < n; i++) begin
         exp_lvl.push_back(lvl);
         exp_dn.push_back(1'b0);
         exp_tag.push_back(tag);
      end
   endtask

   // Expected line for one frame, from the values present at its first edge
   task automatic build_frame();
      longint used = 0;
      longint idle;
      bit     prev_zero = 1'b0;
      string  itag;
      for (int c = 0; c < NCH; c++) begin
         int w = int'(vals[c*VW +: VW]);
         push(SEP, 1'b0, prev_zero ? "R8" : "R2");
         push(w, 1'b1, chan_tag);
         prev_zero = (w == 0);
         used += SEP + w;
      end
      push(SEP, 1'b0, prev_zero ? "R8" : "R2");
      used += SEP;
      if (used + SEP <= FRM) begin idle = FRM - used; itag = "R4"; end
      else                   begin idle = SEP;        itag = "R5"; end
      push(int'(idle) - 1, 1'b1, itag);
      exp_lvl.push_back(1'b1);
      exp_dn.push_back(1'b1);
      exp_tag.push_back("R6");
   endtask

   task automatic check_pins(input string tag, input bit el, input bit ed);
      checks++;
      if (ppm !== el || done !== ed) begin
         failures++;
         $display("FAIL %s cycle %0d: ppm=%0b done=%0b expected ppm=%0b done=%0b",
                  tag, cyc, ppm, done, el, ed);
      end
   endtask

   task automatic step();
      bit    el, ed;
      string t;
      @(negedge clk);
      if (exp_lvl.size() == 0) build_frame();
      el = exp_lvl.pop_front();
      ed = exp_dn.pop_front();
      t  = exp_tag.pop_front();
      check_pins(t, el, ed);
   endtask

   task automatic run(input int n);
      for (int i = 0; i < n; i++) step();
   endtask

   // R1: reset level, one high boot cycle, then the model restarts
   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      #1 check_pins("R1", 1'b1, 1'b0);
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         check_pins("R1", 1'b1, 1'b0);
      end
      @(negedge clk);
      rst_n = 1'b1;
      #1 check_pins("R1", 1'b1, 1'b0);
      exp_lvl.delete();
      exp_dn.delete();
      exp_tag.delete();
   endtask

   initial begin
      set_vals(5, 10, 15, 20, 25, 30);
      do_reset();
      // R3 and R4: ordinary widths, frame filled to its period
      run(2 * FRM);

      // R7: values rewritten in mid-frame take effect at the next frame
      chan_tag = "R7";
      run(50);
      set_vals(30, 1, 2, 3, 4, 5);
      run(60);
      set_vals(2, 4, 6, 8, 10, 12);
      run(500);
      chan_tag = "R3";

      // R8: zero-width channels, including the first and the last
      set_vals(0, 12, 0, 7, 9, 0);
      run(450);
      set_vals(0, 0, 0, 0, 0, 0);
      run(450);

      // R4 boundary: U = FRM - SEP, idle equals one separator
      set_vals(20, 20, 20, 20, 20, 36);
      run(450);
      // R5: U exactly at the frame period
      set_vals(24, 24, 24, 24, 24, 24);
      run(450);
      // R5: pulses far beyond the frame period
      set_vals(100, 100, 100, 100, 100, 100);
      run(1400);
      // R3: shortest nonzero pulses
      set_vals(1, 1, 1, 1, 1, 1);
      run(450);

      // R1: reset in the middle of a frame
      set_vals(7, 14, 21, 28, 35, 42);
      run(90);
      do_reset();
      run(450);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(8 * 100000);
      failures++;
      $display("FAIL watchdog: run did not finish, cycle %0d expected end earlier", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule